// File: doc/BRIEF.md
# Dual Wiper Register Command Executor

This block is the register and command core behind a two-channel digital potentiometer. Each channel has a volatile 6-bit wiper register, which sets the tap, and four data registers that stand in for nonvolatile storage. A serial front end, not part of this block, sends three kinds of event: the decoded instruction byte, the data byte of a three-byte command, and the stop condition. The block runs reads, writes, single-channel transfers and all-channel transfers between the wiper registers and the data registers.

Any write into a data register is treated as a slow store. It raises `busy` for a programmable number of clock cycles. The front end uses `busy` to refuse new commands. Stores are blocked while the write-protect input is low. Loads into a wiper register take effect at once. Each wiper position is output both as a binary code and as a one-hot select over 64 taps.

Top module: `wcx_exec`

## Requirements
- R1: The instruction byte is split as follows: bits 7:4 are the opcode, bits 3:2 are the data-register index, and bit 0 is the channel. Bit 1 has no effect.
- R2: Opcode 1001 (read wiper) and opcode 1011 (read data register) put `{2'b00, value}` on `rd_byte` in the cycle after `cmd_valid`.
- R3: After opcode 1010, the next `data_byte` writes bits 5:0 into the selected wiper. The change is visible on `wiper_code` one cycle after `data_valid`, and it does not raise `busy`.
- R4: After opcode 1100, the next `data_byte` stores bits 5:0 into the selected data register and starts a store. Bits 7:6 of the data byte are ignored.
- R5: Opcode 1101 loads the selected wiper from its channel's selected data register. Opcode 0001 does the same for both channels with the same index. Both act only on `stop_pulse`.
- R6: Opcode 1110 stores the selected wiper into its channel's selected data register. Opcode 1000 does the same for both channels with the same index. Both act on `stop_pulse` and start a store.
- R7: A store holds `busy` high from the cycle after it commits, for `store_ticks` cycles. The count is clamped to at least 1 and at most `MAX_STORE_CYCLES`.
- R8: While `wp_n` is low, a store leaves every data register unchanged and does not raise `busy`. Wiper writes and loads still work.
- R9: While `busy` is high, `cmd_valid`, `data_valid` and `stop_pulse` are ignored.
- R10: Reset loads the data registers from `DR_IMAGE` and loads each wiper from its channel's data register 0.
- R11: For each channel, `tap_sel` has exactly one bit set, at the index given by that channel's `wiper_code`.
- R12: Opcodes not listed above, including 0010, change no register. This also holds when a data byte and a stop follow them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up recall) |
| wp_n | input | 1 | Write protect; low blocks stores |
| store_ticks | input | TICK_W | Store duration in cycles |
| cmd_valid | input | 1 | Instruction byte strobe |
| cmd_byte | input | 8 | Instruction byte |
| data_valid | input | 1 | Data byte strobe |
| data_byte | input | 8 | Data byte |
| stop_pulse | input | 1 | Stop condition seen |
| busy | output | 1 | Store in progress |
| rd_byte | output | 8 | Byte to return for read commands |
| wiper_code | output | 12 | Channel 1 in bits 11:6, channel 0 in bits 5:0 |
| tap_sel | output | 128 | One-hot tap select; channel 1 in the upper 64 bits |

## Verification
The hardest case to reach is traffic that arrives while a store is still running. Reaching it needs three things: a store that lasts long enough, a command sequence that follows straight after, and a check afterwards that nothing moved. The bench sets `store_ticks` to 20 and starts a data-register store. It then sends a full wiper write (instruction, data and stop) inside the busy window, waits for idle, and reads the wiper back. In the same way, it checks the clamp at both ends by counting busy cycles for 0, 5 and a value above the maximum.

// File: rtl/wcx_pkg.sv
package wcx_pkg;
    localparam int WIPER_W  = 6;
    localparam int NDR      = 4;
    localparam int NCH      = 2;
    localparam int DR_SEL_W = $clog2(NDR);
    localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int TAPS     = 1 << WIPER_W;

    typedef logic [3:0] op_t;
    localparam op_t OP_GLD_ALL = 4'b0001;
    localparam op_t OP_STEP    = 4'b0010;
    localparam op_t OP_GST_ALL = 4'b1000;
    localparam op_t OP_RD_WIP  = 4'b1001;
    localparam op_t OP_WR_WIP  = 4'b1010;
    localparam op_t OP_RD_DR   = 4'b1011;
    localparam op_t OP_WR_DR   = 4'b1100;
    localparam op_t OP_LD_WIP  = 4'b1101;
    localparam op_t OP_ST_WIP  = 4'b1110;

    typedef logic [WIPER_W-1:0] code_t;
    typedef code_t [NCH-1:0][NDR-1:0] dr_arr_t;
    typedef code_t [NCH-1:0] wip_arr_t;

    typedef struct packed {
        logic                known;
        op_t                 op;
        logic [DR_SEL_W-1:0] idx;
        logic [CH_W-1:0]     ch;
    } cmd_t;

    typedef struct packed {
        dr_arr_t  dr;
        wip_arr_t wiper;
        logic     pend_v;
        cmd_t     pend;
        logic [7:0] rd;
    } exec_st_t;
endpackage

// File: rtl/wcx_cmd_decode.sv
module wcx_cmd_decode
    import wcx_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_t       cmd
);
    logic unused_rsv;
    assign unused_rsv = cmd_byte[1];

    always_comb begin
        cmd.op  = cmd_byte[7:4];
        cmd.idx = cmd_byte[3:2];
        cmd.ch  = cmd_byte[0];
        case (cmd_byte[7:4])
            OP_GLD_ALL, OP_GST_ALL, OP_RD_WIP, OP_WR_WIP,
            OP_RD_DR, OP_WR_DR, OP_LD_WIP, OP_ST_WIP: cmd.known = 1'b1;
            default:                                  cmd.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/wcx_store_timer.sv
module wcx_store_timer #(
    parameter int MAX_CYCLES = 2000000,
    parameter int CNT_W      = $clog2(MAX_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] ticks,
    output logic             busy
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q, len;

    always_comb begin
        if (ticks == '0)      len = CNT_W'(1);
        else if (ticks > CAP) len = CAP;
        else                  len = ticks;

        if (start)             cnt_d = len;
        else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/wcx_tap_decode.sv
module wcx_tap_decode #(
    parameter int CODE_W = 6,
    parameter int N_TAPS = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [N_TAPS-1:0] sel
);
    always_comb begin
        sel = '0;
        sel[code] = 1'b1;
    end
endmodule

// File: rtl/wcx_exec.sv
module wcx_exec
    import wcx_pkg::*;
#(
    parameter int                         MAX_STORE_CYCLES = 2000000,
    parameter logic [NCH*NDR*WIPER_W-1:0] DR_IMAGE = {6'h3C, 6'h22, 6'h07, 6'h2A,
                                                      6'h01, 6'h30, 6'h0A, 6'h15},
    parameter int                         TICK_W = $clog2(MAX_STORE_CYCLES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wp_n,
    input  logic [TICK_W-1:0]         store_ticks,
    input  logic                      cmd_valid,
    input  logic [7:0]                cmd_byte,
    input  logic                      data_valid,
    input  logic [7:0]                data_byte,
    input  logic                      stop_pulse,
    output logic                      busy,
    output logic [7:0]                rd_byte,
    output logic [NCH*WIPER_W-1:0]    wiper_code,
    output logic [NCH*TAPS-1:0]       tap_sel
);
    exec_st_t st_d, st_q, st_rst;
    cmd_t     cmd;
    logic     store_go;
    logic     unused_hi;

    assign unused_hi = ^data_byte[7:6];

    wcx_cmd_decode u_dec (
        .cmd_byte (cmd_byte),
        .cmd      (cmd)
    );

    wcx_store_timer #(
        .MAX_CYCLES (MAX_STORE_CYCLES),
        .CNT_W      (TICK_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (store_go),
        .ticks (store_ticks),
        .busy  (busy)
    );

    // Power-up image: data array from parameter, wiper recalled from slot 0
    always_comb begin
        st_rst        = '0;
        st_rst.dr     = dr_arr_t'(DR_IMAGE);
        for (int c = 0; c < NCH; c++) begin
            st_rst.wiper[c] = st_rst.dr[c][0];
        end
    end

    always_comb begin
        st_d     = st_q;
        store_go = 1'b0;
        if (!busy) begin
            if (cmd_valid) begin
                st_d.pend_v = cmd.known;
                st_d.pend   = cmd;
                case (cmd.op)
                    OP_RD_WIP: st_d.rd = {2'b00, st_q.wiper[cmd.ch]};
                    OP_RD_DR:  st_d.rd = {2'b00, st_q.dr[cmd.ch][cmd.idx]};
                    default:   st_d.rd = st_q.rd;
                endcase
            end else if (data_valid && st_q.pend_v) begin
                case (st_q.pend.op)
                    OP_WR_WIP: begin
                        st_d.wiper[st_q.pend.ch] = data_byte[WIPER_W-1:0];
                        st_d.pend_v = 1'b0;
                    end
                    OP_WR_DR: begin
                        if (wp_n) begin
                            st_d.dr[st_q.pend.ch][st_q.pend.idx] = data_byte[WIPER_W-1:0];
                            store_go = 1'b1;
                        end
                        st_d.pend_v = 1'b0;
                    end
                    default: ;
                endcase
            end else if (stop_pulse) begin
                if (st_q.pend_v) begin
                    case (st_q.pend.op)
                        OP_LD_WIP: st_d.wiper[st_q.pend.ch] = st_q.dr[st_q.pend.ch][st_q.pend.idx];
                        OP_ST_WIP: begin
                            if (wp_n) begin
                                st_d.dr[st_q.pend.ch][st_q.pend.idx] = st_q.wiper[st_q.pend.ch];
                                store_go = 1'b1;
                            end
                        end
                        OP_GLD_ALL: begin
                            for (int c = 0; c < NCH; c++) begin
                                st_d.wiper[c] = st_q.dr[c][st_q.pend.idx];
                            end
                        end
                        OP_GST_ALL: begin
                            if (wp_n) begin
                                for (int c = 0; c < NCH; c++) begin
                                    st_d.dr[c][st_q.pend.idx] = st_q.wiper[c];
                                end
                                store_go = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                st_d.pend_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign rd_byte    = st_q.rd;
    assign wiper_code = st_q.wiper;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_tap
            wcx_tap_decode #(
                .CODE_W (WIPER_W),
                .N_TAPS (TAPS)
            ) u_tap (
                .code (st_q.wiper[g]),
                .sel  (tap_sel[g*TAPS +: TAPS])
            );
        end
    endgenerate
endmodule

// File: rtl/wcx_exec_chk.sv
module wcx_exec_chk
    import wcx_pkg::*;
#(
    parameter int MAX_STORE_CYCLES = 2000000
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wp_n,
    input logic                      busy,
    input logic                      data_valid,
    input logic                      stop_pulse,
    input logic [NCH*WIPER_W-1:0]    wiper_code,
    input logic [NCH*TAPS-1:0]       tap_sel,
    input logic [NCH*NDR*WIPER_W-1:0] dr_flat
);
    localparam int BW = $clog2(MAX_STORE_CYCLES + 2);
    logic [BW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + BW'(1);
        else           run_q <= '0;
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_oh
            assert_tap_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
                ($countones(tap_sel[g*TAPS +: TAPS]) == 1) &&
                tap_sel[g*TAPS + int'(wiper_code[g*WIPER_W +: WIPER_W])]);
        end
    endgenerate

    assert_busy_needs_wp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wp_n));

    assert_dr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wp_n) |-> $stable(dr_flat));

    assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= BW'(MAX_STORE_CYCLES));

    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wiper_code));

    assert_wiper_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_code) |-> $past(data_valid || stop_pulse));
endmodule

bind wcx_exec wcx_exec_chk #(
    .MAX_STORE_CYCLES (MAX_STORE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_n       (wp_n),
    .busy       (busy),
    .data_valid (data_valid),
    .stop_pulse (stop_pulse),
    .wiper_code (wiper_code),
    .tap_sel    (tap_sel),
    .dr_flat    (st_q.dr)
);

// File: tb/tb_wcx_exec.sv
module tb_wcx_exec;
    localparam int MAXC = 40;
    localparam int TW   = 6;
    localparam logic [47:0] IMG = {6'h3C, 6'h22, 6'h07, 6'h2A,
                                   6'h01, 6'h30, 6'h0A, 6'h15};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n = 1'b1;
    logic [TW-1:0] store_ticks = TW'(5);
    logic          cmd_valid = 1'b0, data_valid = 1'b0, stop_pulse = 1'b0;
    logic [7:0]    cmd_byte = '0, data_byte = '0;
    logic          busy;
    logic [7:0]    rd_byte;
    logic [11:0]   wiper_code;
    logic [127:0]  tap_sel;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wcx_exec #(.MAX_STORE_CYCLES(MAXC), .DR_IMAGE(IMG)) dut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .store_ticks(store_ticks),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .data_valid(data_valid),
        .data_byte(data_byte), .stop_pulse(stop_pulse), .busy(busy),
        .rd_byte(rd_byte), .wiper_code(wiper_code), .tap_sel(tap_sel));

    // {cmd, data, has_data, is_read, expected}
    localparam int NV = 22;
    localparam logic [25:0] VEC [NV] = '{
        {8'hA0, 8'h05, 1'b1, 1'b0, 8'h00},  // R3 wiper0 = 05
        {8'h90, 8'h00, 1'b0, 1'b1, 8'h05},  // R2
        {8'h92, 8'h00, 1'b0, 1'b1, 8'h05},  // R1 bit1 no effect
        {8'hA1, 8'h3F, 1'b1, 1'b0, 8'h00},  // R1 channel 1
        {8'h91, 8'h00, 1'b0, 1'b1, 8'h3F},
        {8'hC8, 8'hD1, 1'b1, 1'b0, 8'h00},  // R4 dr[0][2]=11, hi bits dropped
        {8'hB8, 8'h00, 1'b0, 1'b1, 8'h11},  // R4
        {8'hD8, 8'h00, 1'b0, 1'b0, 8'h00},  // R5 load wiper0 from dr2
        {8'h90, 8'h00, 1'b0, 1'b1, 8'h11},
        {8'hE5, 8'h00, 1'b0, 1'b0, 8'h00},  // R6 dr[1][1] = 3F
        {8'hB5, 8'h00, 1'b0, 1'b1, 8'h3F},
        {8'h14, 8'h00, 1'b0, 1'b0, 8'h00},  // R5 global load idx1
        {8'h90, 8'h00, 1'b0, 1'b1, 8'h0A},
        {8'h91, 8'h00, 1'b0, 1'b1, 8'h3F},
        {8'h8C, 8'h00, 1'b0, 1'b0, 8'h00},  // R6 global store idx3
        {8'hBC, 8'h00, 1'b0, 1'b1, 8'h0A},
        {8'hBD, 8'h00, 1'b0, 1'b1, 8'h3F},
        {8'h70, 8'h2A, 1'b1, 1'b0, 8'h00},  // R12 unlisted
        {8'h90, 8'h00, 1'b0, 1'b1, 8'h0A},
        {8'h21, 8'h00, 1'b0, 1'b0, 8'h00},  // R12 step opcode
        {8'h91, 8'h00, 1'b0, 1'b1, 8'h3F},
        {8'hB1, 8'h00, 1'b0, 1'b1, 8'h2A}   // R10 image dr[1][0]
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] b);
        @(negedge clk); cmd_byte = b; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic send_data(input logic [7:0] b);
        @(negedge clk); data_byte = b; data_valid = 1'b1;
        @(negedge clk); data_valid = 1'b0;
    endtask

    task automatic send_stop();
        @(negedge clk); stop_pulse = 1'b1;
        @(negedge clk); stop_pulse = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic chk_taps(input string req);
        chk(req, 16'(tap_sel[63:0]   == (64'd1 << wiper_code[5:0])), 16'd1);
        chk(req, 16'(tap_sel[127:64] == (64'd1 << wiper_code[11:6])), 16'd1);
    endtask

    initial begin
        int n;
        do_reset();
        // R10 reset recall, R11 taps
        chk("R10 wipers", 16'(wiper_code), {4'h0, 6'h2A, 6'h15});
        chk("R10 busy", 16'(busy), 16'd0);
        chk_taps("R11 after reset");

        for (int i = 0; i < NV; i++) begin
            send_cmd(VEC[i][25:18]);
            if (VEC[i][8]) chk($sformatf("R2 vec%0d", i), 16'(rd_byte), 16'(VEC[i][7:0]));
            if (VEC[i][9]) send_data(VEC[i][17:10]);
            send_stop();
            wait_idle();
        end
        chk_taps("R11 after table");

        do_reset();
        // R3: immediate wiper write, no busy
        send_cmd(8'hA0); send_data(8'h07);
        chk("R3 immediate", 16'(wiper_code[5:0]), 16'h07);
        chk("R3 no busy", 16'(busy), 16'd0);
        send_stop();
        // R5: load only at stop
        send_cmd(8'hD0);
        @(negedge clk);
        chk("R5 before stop", 16'(wiper_code[5:0]), 16'h07);
        send_stop();
        chk("R5 at stop", 16'(wiper_code[5:0]), 16'h15);

        // R7: busy lengths
        store_ticks = TW'(5);
        send_cmd(8'hC4); send_data(8'h09); busy_len(n);
        chk("R7 len 5", 16'(n), 16'd5);
        store_ticks = TW'(63);
        send_cmd(8'hC4); send_data(8'h09); busy_len(n);
        chk("R7 clamp max", 16'(n), 16'(MAXC));
        store_ticks = TW'(0);
        send_cmd(8'hE0); send_stop(); busy_len(n);
        chk("R7 clamp min", 16'(n), 16'd1);

        // R9: traffic during busy ignored (wiper0 = 15, dr[0][0]=15)
        store_ticks = TW'(20);
        send_cmd(8'hC4); send_data(8'h0C);
        send_cmd(8'hA0); send_data(8'h3E); send_stop();
        chk("R9 still busy", 16'(busy), 16'd1);
        wait_idle();
        chk("R9 wiper kept", 16'(wiper_code[5:0]), 16'h15);
        send_cmd(8'h90); send_stop();
        chk("R9 readback", 16'(rd_byte), 16'h15);

        // R8: write protect
        wp_n = 1'b0;
        send_cmd(8'hC0); send_data(8'h33);
        chk("R8 no busy dr write", 16'(busy), 16'd0);
        send_stop();
        send_cmd(8'hA0); send_data(8'h2F); send_stop();
        chk("R8 wiper write allowed", 16'(wiper_code[5:0]), 16'h2F);
        send_cmd(8'hE0); send_stop();
        chk("R8 no busy wiper store", 16'(busy), 16'd0);
        wp_n = 1'b1;
        send_cmd(8'hB0);
        chk("R8 dr unchanged", 16'(rd_byte), 16'h15);
        send_stop();

        // R10: reset recalls slot 0
        send_cmd(8'hA1); send_data(8'h01); send_stop();
        do_reset();
        chk("R10 recall", 16'(wiper_code), {4'h0, 6'h2A, 6'h15});
        chk_taps("R11 after recall");

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule